// File: doc/BRIEF.md
# DRAM Refresh Row Scheduler

This block decides when DRAM rows get refreshed and which row is next. A cycle timer measures refresh periods and a wrapping row counter holds the index of the next row due. When a period expires, the block raises a refresh request toward the memory command arbiter. The arbiter answers with a grant. Each granted request stands for one row: the arbiter reads that row and writes it back, because a read destroys the stored charge.

The retention window and the row count are both parameters, counted in clock cycles and rows. A static mode input selects one of two schedules:

- **Spread mode.** One row is requested every floor(window / rows) cycles, so the request rate grows with the number of rows.
- **Burst mode.** Once per full window, the block requests every row back to back.

A sticky flag reports that a refresh period expired while earlier work was still waiting for a grant.

Top module: `rfsh_sched`

## Requirements
- R1: With `burst_mode_i` low (spread mode), a new single-row request is raised every GAP = floor(WINDOW_CYC / ROWS) cycles. When each request is granted at once, `ref_req_o` is high for one cycle in every GAP.
- R2: With `burst_mode_i` high (burst mode), `ref_req_o` is raised every WINDOW_CYC cycles. It then stays high until ROWS grants are taken, so with an always-high grant it is high for ROWS consecutive cycles per window.
- R3: `ref_row_o` advances by one on the clock edge after each accepted grant (`ref_req_o` and `ref_gnt_i` both high). After ROWS-1 it wraps to 0, and it never holds a value of ROWS or more.
- R4: A request that is not granted stays asserted, and `ref_row_o` holds its value meanwhile.
- R5: If a refresh period expires while a request is still pending and not completed by a grant in that cycle, `missed_o` goes high one edge later and stays high until reset.
- R6: While `rst_ni` is low, `ref_req_o` and `missed_o` are 0 and `ref_row_o` is 0. Reset is released through a two-stage synchronizer. The first request appears after the (P+2)-th rising edge following the release, where P is the active period (GAP or WINDOW_CYC).
- R7: `ref_gnt_i` has no effect while `ref_req_o` is low: `ref_row_o` does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| burst_mode_i | input | 1 | Static schedule select: 0 spread, 1 burst |
| ref_req_o | output | 1 | Refresh request toward the arbiter |
| ref_gnt_i | input | 1 | Grant from the arbiter; with `ref_req_o`, one row is taken |
| ref_row_o | output | $clog2(ROWS) | Row to refresh for the current request |
| missed_o | output | 1 | Sticky flag: a period expired with work still pending |

## Verification
Timing is counted from the release of `rst_ni`:

- Two edges pass in the synchronizer.
- The timer then runs P edges, so a request is visible after edge P+2.
- A grant moves the row and drops a single request at the very next edge.
- A missed period shows on `missed_o` one edge after the expiring cycle.

The bench counts rising edges from the release and samples every output on the falling edge that follows. It compares each sample with the expected value for that edge count: (n-2) mod P must be below 1 in spread mode and below ROWS in burst mode. The expected row is the number of grants the bench itself has issued, taken modulo ROWS.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic {
    MODE_SPREAD = 1'b0,
    MODE_BURST  = 1'b1
  } rfsh_mode_e;

  function automatic int unsigned spread_gap(input int unsigned win_cyc,
                                             input int unsigned rows);
    return (win_cyc / rows);
  endfunction

endpackage

// File: rtl/rfsh_rst_sync.sv
module rfsh_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_val;

  assign last_val = period_i - CNT_W'(1);
  assign tick_o   = (cnt_q == last_val);

  always_comb begin
    if (tick_o) cnt_d = '0;
    else        cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_TIMER_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period_i); // R1

  AST_TIMER_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned ROW_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    row_d = row_q;
    if (adv_i) begin
      if (row_q == LAST_ROW) row_d = '0;
      else                   row_d = row_q + ROW_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_q <= '0;
    else         row_q <= row_d;
  end

  assign row_o = row_q;

  AST_ROW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_q <= LAST_ROW); // R3

  AST_ROW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && row_q == LAST_ROW) |=> (row_q == '0)); // R3

  AST_ROW_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(row_q)); // R4
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int unsigned ROWS       = 8192,
  parameter int unsigned WINDOW_CYC = 16000000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    burst_mode_i,
  output logic                    ref_req_o,
  input  logic                    ref_gnt_i,
  output logic [$clog2(ROWS)-1:0] ref_row_o,
  output logic                    missed_o
);
  import rfsh_pkg::*;

  localparam int unsigned ROW_W = $clog2(ROWS);
  localparam int unsigned CNT_W = $clog2(WINDOW_CYC + 1);
  localparam int unsigned REM_W = $clog2(ROWS + 1);
  localparam int unsigned GAP   = spread_gap(WINDOW_CYC, ROWS);

  localparam logic [CNT_W-1:0] GAP_CYC  = CNT_W'(GAP);
  localparam logic [CNT_W-1:0] WIN_CYC  = CNT_W'(WINDOW_CYC);
  localparam logic [REM_W-1:0] ALL_ROWS = REM_W'(ROWS);
  localparam logic [REM_W-1:0] ONE_ROW  = REM_W'(1);

  rfsh_mode_e       mode;
  logic             rst_n_core;
  logic [CNT_W-1:0] period;
  logic             tick;
  logic             grant;
  logic             last_grant;
  logic             still_pending;
  logic [REM_W-1:0] remain_q;
  logic [REM_W-1:0] remain_d;
  logic [REM_W-1:0] load_val;
  logic             missed_q;
  logic             missed_d;

  assign mode = rfsh_mode_e'(burst_mode_i);

  rfsh_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_core)
  );

  always_comb begin
    if (mode == MODE_BURST) begin
      period   = WIN_CYC;
      load_val = ALL_ROWS;
    end else begin
      period   = GAP_CYC;
      load_val = ONE_ROW;
    end
  end

  rfsh_tick_gen #(.CNT_W(CNT_W)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_core),
    .period_i (period),
    .tick_o   (tick)
  );

  assign ref_req_o     = (remain_q != '0);
  assign grant         = ref_req_o & ref_gnt_i;
  assign last_grant    = grant & (remain_q == ONE_ROW);
  assign still_pending = ref_req_o & ~last_grant;

  always_comb begin
    remain_d = remain_q;
    if (tick && !still_pending) remain_d = load_val;
    else if (grant)             remain_d = remain_q - ONE_ROW;
  end

  always_comb begin
    missed_d = missed_q | (tick & still_pending);
  end

  always_ff @(posedge clk_i or negedge rst_n_core) begin
    if (!rst_n_core) begin
      remain_q <= '0;
      missed_q <= 1'b0;
    end else begin
      remain_q <= remain_d;
      missed_q <= missed_d;
    end
  end

  rfsh_row_ctr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_n_core),
    .adv_i  (grant),
    .row_o  (ref_row_o)
  );

  assign missed_o = missed_q;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_core)
    (ref_req_o && !ref_gnt_i) |=> ref_req_o); // R4

  AST_ROW_FROZEN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_n_core)
    (ref_req_o && !ref_gnt_i) |=> $stable(ref_row_o)); // R4

  AST_GNT_IGNORED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_core)
    (!ref_req_o && ref_gnt_i) |=> $stable(ref_row_o)); // R7

  AST_MISSED_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n_core)
    missed_o |=> missed_o); // R5

  AST_MISSED_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n_core)
    $rose(missed_o) |-> $past(ref_req_o)); // R5

  AST_SPREAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_core)
    (!burst_mode_i && ref_req_o && ref_gnt_i) |=> !ref_req_o || $past(tick)); // R1

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_n_core |-> (!ref_req_o && !missed_o)); // R6
endmodule

// File: tb/rfsh_sched_tb_top.sv
`timescale 1ns/1ps
module rfsh_sched_tb_top;
  localparam int unsigned ROWS = 5;
  localparam int unsigned WIN  = 23;
  localparam int unsigned GAP  = WIN / ROWS;
  localparam int unsigned RW   = $clog2(ROWS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          burst;
  logic          gnt;
  logic          req;
  logic          missed;
  logic [RW-1:0] row;

  int n_chk  = 0;
  int n_fail = 0;
  int edge_n = 0;

  always #2 clk = ~clk;

  rfsh_sched #(.ROWS(ROWS), .WINDOW_CYC(WIN)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .burst_mode_i (burst),
    .ref_req_o    (req),
    .ref_gnt_i    (gnt),
    .ref_row_o    (row),
    .missed_o     (missed)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s edge %0d: actual %0d expected %0d", tag, edge_n, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    edge_n++;
  endtask

  task automatic do_reset(input bit b);
    @(negedge clk);
    rst_n = 1'b0;
    burst = b;
    gnt   = 1'b0;
    repeat (3) @(negedge clk);
    chk(req == 1'b0,    "R6 req in reset",    int'(req),    0);
    chk(row == '0,      "R6 row in reset",    int'(row),    0);
    chk(missed == 1'b0, "R6 missed in reset", int'(missed), 0);
    rst_n  = 1'b1;
    edge_n = 0;
  endtask

  // Always-granted sweep: request high when m = n-2 >= P and m % P < L.
  task automatic sweep(input bit b, input int edges);
    int p;
    int l;
    int grants;
    p      = b ? WIN : GAP;
    l      = b ? ROWS : 1;
    grants = 0;
    do_reset(b);
    gnt = 1'b1;
    for (int k = 0; k < edges; k++) begin
      int  m;
      bit  exp_req;
      step();
      m       = edge_n - 2;
      exp_req = (m >= p) && ((m % p) < l);
      if (edge_n <= p + 2)
        chk(req == exp_req, "R6 first request", int'(req), int'(exp_req));
      else if (b)
        chk(req == exp_req, "R2 burst request", int'(req), int'(exp_req));
      else
        chk(req == exp_req, "R1 spread request", int'(req), int'(exp_req));
      chk(int'(row) == grants % ROWS, "R3 row index", int'(row), grants % ROWS);
      chk(missed == 1'b0, "R5 no miss with prompt grants", int'(missed), 0);
      if (exp_req) grants++;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    burst = 1'b0;
    gnt   = 1'b0;

    sweep(1'b0, 70);
    sweep(1'b1, 130);

    // Stalled request in spread mode: request rises after edge 6.
    do_reset(1'b0);
    for (int k = 1; k <= 9; k++) begin
      step();
      if (k >= GAP + 2) chk(req == 1'b1, "R4 request held", int'(req), 1);
      chk(row == '0, "R4 row held while waiting", int'(row), 0);
      chk(missed == 1'b0, "R5 no miss yet", int'(missed), 0);
    end
    step(); // edge 10: second period expired while pending
    chk(missed == 1'b1, "R5 miss flagged", int'(missed), 1);
    chk(req == 1'b1, "R4 request still held", int'(req), 1);
    gnt = 1'b1;
    step(); // edge 11: grant taken
    chk(int'(row) == 1, "R3 row after grant", int'(row), 1);
    chk(req == 1'b0, "R1 request dropped after grant", int'(req), 0);
    step(); // edge 12: grant while idle
    chk(int'(row) == 1, "R7 idle grant ignored", int'(row), 1);
    step(); // edge 13
    chk(int'(row) == 1, "R7 idle grant ignored", int'(row), 1);
    gnt = 1'b0;
    step(); // edge 14: next request
    chk(req == 1'b1, "R1 next request", int'(req), 1);
    chk(missed == 1'b1, "R5 miss sticky", int'(missed), 1);
    do_reset(1'b0);
    step();
    chk(missed == 1'b0, "R6 miss cleared by reset", int'(missed), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule